// File: doc/BRIEF.md
# Scan Test Access Port Controller with Instruction Decode

This block is the serial test port of a device that has no boundary-scan cells. It follows TMS on every rising TCK edge through the sixteen-state test-port sequence. It holds a five-bit instruction in a shift stage and an active stage, and it routes either a one-bit pass-through stage or a small placeholder configuration data register between TDI and TDO.

The decoded instruction drives two control outputs. Configuration commands (program, erase, verify) do not act when they are loaded. They raise `testMode` once the controller settles in Run-Test/Idle, and keep it high for as long as the controller stays there. Every other command takes effect at Update-IR, which produces a single-cycle `execStrobe`. Board-level test software uses the port to chain this device with others: unsupported or boundary-related codes fall back to the pass-through stage, so the whole chain stays usable.

Top module: `scan_tap_ctl`

## Requirements
- R1: An asynchronous low on `trstN` puts the controller in Test-Logic-Reset, sets `irActive` to 11111, and drives `tdoEn`, `testMode` and `execStrobe` low.
- R2: Five rising TCK edges with TMS=1 reach Test-Logic-Reset from any state, and the next edge reloads `irActive` with 11111. Four such edges are not enough.
- R3: TMS at each rising edge picks the next state. Capture goes to Shift (0) or Exit1 (1). Exit1 goes to Pause (0) or Update (1). Pause holds (0) or goes to Exit2 (1). Exit2 goes back to Shift (0) or to Update (1).
- R4: Capture-IR loads 00001 into the instruction shift stage. Shifting moves TDI into the MSB and sends the LSB to TDO first. The shifted code becomes `irActive` on the edge that leaves Update-IR.
- R5: `tdoEn` is high only in Shift-DR and Shift-IR. `tdo` and `tdoEn` change on the falling edge of TCK.
- R6: The codes 11111 (bypass), 11100 (sample/preload), 00000 (extest) and every unassigned code select the one-bit pass-through stage. Capture-DR loads 0 into that stage, and in Shift-DR each TDI bit shows up on `tdo` at the next falling edge.
- R7: The configuration codes 10000 (program), 10001 (erase) and 10010 (verify) select a CFG_W-bit data register. Capture-DR loads it from `cfgData`, it shifts LSB first, and Update-DR copies it to `cfgData`.
- R8: `testMode` is high exactly while the controller is in Run-Test/Idle with a configuration code in `irActive`. It goes high on the first edge that enters Run-Test/Idle after that code is loaded.
- R9: `execStrobe` is high for exactly one TCK cycle after the edge that leaves Update-IR with a non-configuration code. It never pulses for a configuration code.
- R10: Pause-DR and Pause-IR leave the shift contents unchanged, so a shift that is paused and then resumed gives the same result as one that is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising TCK edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdoEn | output | 1 | Output enable for `tdo`; high in shift states only |
| testMode | output | 1 | Configuration operation active in Run-Test/Idle |
| execStrobe | output | 1 | One-cycle pulse for a non-configuration command |
| irActive | output | 5 | Instruction currently in force |
| cfgData | output | CFG_W | Held contents of the placeholder configuration register |

## Verification
The edge that leaves Update-IR and enters Run-Test/Idle is the one cycle where `execStrobe` and `testMode` can both switch. Which one rises depends only on the code that was just loaded. The bench loads configuration and non-configuration codes back to back, each time going straight from Update-IR into Run-Test/Idle. It samples both outputs in the cycle that follows: exactly one of them must be high, and only `testMode` may still be high one cycle later.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    TLR, RTI,
    SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tapState_e;

  // strobes from the control FSM to the datapath, all decoded from the current state
  typedef struct packed {
    logic resetLogic;
    logic inIdle;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobe_t;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapState_e  state,
  output tapStrobe_t strb
);

  tapState_e nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      TLR:    nextState = tms ? TLR    : RTI;
      RTI:    nextState = tms ? SEL_DR : RTI;
      SEL_DR: nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR: nextState = tms ? EX1_DR : SH_DR;
      SH_DR:  nextState = tms ? EX1_DR : SH_DR;
      EX1_DR: nextState = tms ? UPD_DR : PAU_DR;
      PAU_DR: nextState = tms ? EX2_DR : PAU_DR;
      EX2_DR: nextState = tms ? UPD_DR : SH_DR;
      UPD_DR: nextState = tms ? SEL_DR : RTI;
      SEL_IR: nextState = tms ? TLR    : CAP_IR;
      CAP_IR: nextState = tms ? EX1_IR : SH_IR;
      SH_IR:  nextState = tms ? EX1_IR : SH_IR;
      EX1_IR: nextState = tms ? UPD_IR : PAU_IR;
      PAU_IR: nextState = tms ? EX2_IR : PAU_IR;
      EX2_IR: nextState = tms ? UPD_IR : SH_IR;
      UPD_IR: nextState = tms ? SEL_DR : RTI;
      default: nextState = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TLR;
    else        state <= nextState;
  end

  always_comb begin
    strb            = '0;
    strb.resetLogic = (state == TLR);
    strb.inIdle     = (state == RTI);
    strb.captureIr  = (state == CAP_IR);
    strb.shiftIr    = (state == SH_IR);
    strb.updateIr   = (state == UPD_IR);
    strb.captureDr  = (state == CAP_DR);
    strb.shiftDr    = (state == SH_DR);
    strb.updateDr   = (state == UPD_DR);
  end

endmodule

// File: rtl/scan_tap_datapath.sv
module scan_tap_datapath
  import scan_tap_pkg::*;
#(
  parameter int IR_W  = 5,
  parameter int CFG_W = 8,
  parameter logic [IR_W-1:0] CODE_PROG   = 5'b10000,
  parameter logic [IR_W-1:0] CODE_ERASE  = 5'b10001,
  parameter logic [IR_W-1:0] CODE_VERIFY = 5'b10010
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  tapStrobe_t       strb,
  output logic             tdo,
  output logic             tdoEn,
  output logic             testMode,
  output logic             execStrobe,
  output logic [IR_W-1:0]  irActive,
  output logic [CFG_W-1:0] cfgData
);

  localparam logic [IR_W-1:0] CODE_BYPASS = '1;
  localparam logic [IR_W-1:0] IR_CAPTURE  = IR_W'(1);

  logic [IR_W-1:0]  irShift;
  logic [CFG_W-1:0] cfgShift;
  logic             bypassBit;
  logic             cfgSel;
  logic             serialOut;

  function automatic logic isCfg(input logic [IR_W-1:0] code);
    return (code == CODE_PROG) || (code == CODE_ERASE) || (code == CODE_VERIFY);
  endfunction

  // every code outside the configuration set, including sample and extest, uses the bypass bit
  assign cfgSel   = isCfg(irActive);
  assign testMode = strb.inIdle && cfgSel;

  // instruction register: shift stage and active stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift    <= IR_CAPTURE;
      irActive   <= CODE_BYPASS;
      execStrobe <= 1'b0;
    end else begin
      execStrobe <= strb.updateIr && !isCfg(irShift);
      if (strb.captureIr)    irShift <= IR_CAPTURE;
      else if (strb.shiftIr) irShift <= {tdi, irShift[IR_W-1:1]};
      if (strb.resetLogic)    irActive <= CODE_BYPASS;
      else if (strb.updateIr) irActive <= irShift;
    end
  end

  // data registers: bypass bit and placeholder configuration register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassBit <= 1'b0;
      cfgShift  <= '0;
      cfgData   <= '0;
    end else begin
      if (strb.captureDr) begin
        bypassBit <= 1'b0;
        if (cfgSel) cfgShift <= cfgData;
      end else if (strb.shiftDr) begin
        bypassBit <= tdi;
        if (cfgSel) cfgShift <= {tdi, cfgShift[CFG_W-1:1]};
      end
      if (strb.updateDr && cfgSel) cfgData <= cfgShift;
    end
  end

  always_comb begin
    if (strb.shiftIr)  serialOut = irShift[0];
    else if (cfgSel)   serialOut = cfgShift[0];
    else               serialOut = bypassBit;
  end

  // output stage on the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialOut;
      tdoEn <= strb.shiftIr || strb.shiftDr;
    end
  end

endmodule

// File: rtl/scan_tap_ctl.sv
module scan_tap_ctl
  import scan_tap_pkg::*;
#(
  parameter int IR_W  = 5,
  parameter int CFG_W = 8
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdoEn,
  output logic             testMode,
  output logic             execStrobe,
  output logic [IR_W-1:0]  irActive,
  output logic [CFG_W-1:0] cfgData
);

  tapState_e  ctlState;
  tapStrobe_t ctlStrb;

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .state (ctlState),
    .strb  (ctlStrb)
  );

  scan_tap_datapath #(
    .IR_W  (IR_W),
    .CFG_W (CFG_W)
  ) u_dp (
    .tck        (tck),
    .trstN      (trstN),
    .tdi        (tdi),
    .strb       (ctlStrb),
    .tdo        (tdo),
    .tdoEn      (tdoEn),
    .testMode   (testMode),
    .execStrobe (execStrobe),
    .irActive   (irActive),
    .cfgData    (cfgData)
  );

endmodule

// File: rtl/scan_tap_ctl_chk.sv
module scan_tap_ctl_chk
  import scan_tap_pkg::*;
#(
  parameter int IR_W = 5
) (
  input logic            tck,
  input logic            trstN,
  input logic            tms,
  input tapState_e       state,
  input logic            tdoEn,
  input logic            testMode,
  input logic            execStrobe,
  input logic [IR_W-1:0] irActive
);

  a_r9_exec_single: assert property (@(posedge tck) disable iff (!trstN)
    execStrobe |=> !execStrobe);

  a_r8_mode_not_exec: assert property (@(posedge tck) disable iff (!trstN)
    testMode |-> !execStrobe);

  a_r2_tlr_bypass: assert property (@(posedge tck) disable iff (!trstN)
    (state == TLR) |=> (irActive == '1));

  a_r3_exit1_pause: assert property (@(posedge tck) disable iff (!trstN)
    (state == EX1_DR && !tms) |=> (state == PAU_DR));

  a_r3_exit2_resume: assert property (@(posedge tck) disable iff (!trstN)
    (state == EX2_IR && !tms) |=> (state == SH_IR));

  a_r5_en_in_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (state == SH_DR || state == SH_IR));

endmodule

bind scan_tap_ctl scan_tap_ctl_chk #(.IR_W(IR_W)) u_chk (
  .tck        (tck),
  .trstN      (trstN),
  .tms        (tms),
  .state      (ctlState),
  .tdoEn      (tdoEn),
  .testMode   (testMode),
  .execStrobe (execStrobe),
  .irActive   (irActive)
);

// File: tb/scan_tap_ctl_bench.sv
`timescale 1ns/1ps
module scan_tap_ctl_bench;

  localparam int CFG_W = 8;
  localparam int WALK_N = 29;
  // {tms, expected tdoEn, expected execStrobe} per step, starting in Test-Logic-Reset
  localparam logic [2:0] WALK [WALK_N] = '{
    3'b000, 3'b100, 3'b000, 3'b010, 3'b010, 3'b100, 3'b000, 3'b000,
    3'b100, 3'b010, 3'b100, 3'b100, 3'b100, 3'b100, 3'b000, 3'b010,
    3'b100, 3'b000, 3'b100, 3'b010, 3'b100, 3'b100, 3'b001, 3'b100,
    3'b100, 3'b000, 3'b100, 3'b100, 3'b001
  };

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdoEn, testMode, execStrobe;
  logic [4:0] irActive;
  logic [CFG_W-1:0] cfgData;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 tck = ~tck;

  scan_tap_ctl #(.IR_W(5), .CFG_W(CFG_W)) u_scan_tap_ctl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdoEn(tdoEn), .testMode(testMode), .execStrobe(execStrobe),
    .irActive(irActive), .cfgData(cfgData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #0.5;
  endtask

  function automatic bit isCfgCode(input logic [4:0] c);
    return c == 5'b10000 || c == 5'b10001 || c == 5'b10010;
  endfunction

  // from Run-Test/Idle: load a code, check the captured pattern and the outputs on return
  task automatic loadIr(input logic [4:0] code);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R4 capture bit0", tdo, 1);
    for (int i = 0; i < 4; i++) begin
      tick(0, code[i]);
      chk("R4 capture upper bits", tdo, 0);
    end
    tick(1, code[4]);
    tick(1, 0);
    tick(0, 0);
    chk("R4 irActive after update", irActive, code);
    chk("R9 execStrobe after Update-IR", execStrobe, !isCfgCode(code));
    chk("R8 testMode on idle entry", testMode, isCfgCode(code));
    tick(0, 0);
    chk("R9 execStrobe single cycle", execStrobe, 0);
    chk("R8 testMode held in idle", testMode, isCfgCode(code));
  endtask

  task automatic toShiftDr();
    tick(1, 0); tick(0, 0); tick(0, 0);
  endtask

  task automatic bypassCheck(input string req);
    logic [3:0] pat = 4'b1101;
    toShiftDr();
    chk({req, " captured zero"}, tdo, 0);
    chk("R5 tdoEn in Shift-DR", tdoEn, 1);
    for (int i = 0; i < 4; i++) begin
      tick(0, pat[i]);
      chk({req, " one-bit path"}, tdo, pat[i]);
    end
    tick(1, 0);
    chk("R5 tdoEn off in Exit1", tdoEn, 0);
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    logic [CFG_W-1:0] pat;
    #1;
    @(negedge tck); #0.5;
    chk("R1 tdoEn", tdoEn, 0);
    chk("R1 irActive", irActive, 5'b11111);
    chk("R1 testMode", testMode, 0);
    chk("R1 execStrobe", execStrobe, 0);
    trstN = 1'b1;
    tms = 1'b1;

    // state walk through pause and exit2 on both paths (R3, R5, R10)
    for (int s = 0; s < WALK_N; s++) begin
      tick(WALK[s][2], 1'b1);
      chk("R3 R5 walk tdoEn", tdoEn, WALK[s][1]);
      chk("R9 walk execStrobe", execStrobe, WALK[s][0]);
    end
    chk("R4 capture then exit1 loads 00001", irActive, 5'b00001);

    bypassCheck("R6 unassigned");
    loadIr(5'b11100); bypassCheck("R6 sample");
    loadIr(5'b00000); bypassCheck("R6 extest");
    loadIr(5'b11111); bypassCheck("R6 bypass");

    // configuration register with a pause in the middle of the shift
    pat = 8'hA5;
    loadIr(5'b10000);
    tick(1, 0);
    chk("R8 testMode off outside idle", testMode, 0);
    tick(0, 0); tick(0, 0);
    chk("R7 captured held value", tdo, 0);
    tick(0, pat[0]); tick(0, pat[1]); tick(0, pat[2]); tick(1, pat[3]);
    tick(0, 0); tick(0, 0);
    chk("R3 stays in Pause", tdoEn, 0);
    tick(1, 0); tick(0, 0);
    chk("R10 resumed Shift-DR", tdoEn, 1);
    tick(0, pat[4]); tick(0, pat[5]); tick(0, pat[6]); tick(1, pat[7]);
    tick(1, 0); tick(0, 0);
    chk("R10 R7 paused shift result", cfgData, pat);
    chk("R8 testMode on re-entry", testMode, 1);
    toShiftDr();
    chk("R7 readback bit0", tdo, pat[0]);
    for (int k = 1; k < CFG_W; k++) begin
      tick(0, 0);
      chk("R7 readback", tdo, pat[k]);
    end
    tick(1, 0); tick(1, 0); tick(0, 0);
    chk("R7 update of shifted zeros", cfgData, 0);

    // back-to-back loads: config and non-config both land on the idle-entry edge
    loadIr(5'b10001);
    loadIr(5'b10010);
    loadIr(5'b00000);
    loadIr(5'b10000);
    loadIr(5'b01010);
    bypassCheck("R6 unassigned 01010");

    // four ones are not enough, five reach Test-Logic-Reset (R2)
    loadIr(5'b00000);
    toShiftDr();
    tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0);
    tick(0, 0);
    chk("R2 four ones keep instruction", irActive, 5'b00000);
    chk("R2 reached Capture-IR not shift", tdoEn, 0);
    tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0);
    tick(0, 0);
    chk("R2 five ones reload bypass", irActive, 5'b11111);

    // asynchronous reset in the middle of an IR shift (R1)
    loadIr(5'b00000);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R5 tdoEn in Shift-IR", tdoEn, 1);
    #0.5 trstN = 1'b0;
    #0.5;
    chk("R1 async tdoEn", tdoEn, 0);
    chk("R1 async irActive", irActive, 5'b11111);
    trstN = 1'b1;
    tick(0, 0);
    chk("R1 idle after reset", tdoEn, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule